// File: doc/BRIEF.md
# GPIO Port with Combined Interrupt

This block is a memory-mapped general-purpose I/O port with up to 32 pins. Software reaches it through a small word-addressed register bus. It can drive each pin from a data register, turn its driver on or off, and make a pin blink. It can invert the sense of any input and read the synchronized, inverted pin levels back. Each pin can also take part in one shared interrupt line.

Inputs first cross into the clock domain through two flops. A per-pin polarity bit then inverts them. The inverted level feeds three things: the data-in readback, a level-interrupt term, and a rising-edge detector. The edge detector latches sticky cause bits, and software acknowledges them by writing zeros. Separate edge and level masks gate these sources. A registered OR of the enabled terms drives the single interrupt output.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, data-out, blink-enable, polarity, cause, edge-mask and level-mask read 0, and the active-low enable register reads all ones. pin_oe_o and irq_o are 0.
- R2: The drive-enable register is active-low. A 0 in bit n sets pin_oe_o[n] to 1 and puts data-out bit n on pin_o[n]. A 1 leaves the pin undriven.
- R3: The data-in register (offset 0x10) reads the synchronized pin level XOR the polarity register (offset 0x0C). Writes to data-in have no effect.
- R4: A pin change is seen by data-in through a two-flop synchronizer. A read that captures on the second clock edge after the change still returns the old level, and a read capturing on the third edge returns the new one.
- R5: A cause bit (offset 0x14) sets when the polarity-adjusted input of its pin goes from 0 to 1. A 1-to-0 transition does not set it, and a set bit stays set until it is acknowledged.
- R6: Writing 0 to a cause bit clears it, and writing 1 leaves it unchanged.
- R7: When a new rising edge and a write-0 acknowledge hit the same cause bit in the same cycle, the bit ends up set.
- R8: The edge term of pin n is cause[n] AND edge-mask[n] (offset 0x18). A pending cause whose mask bit is 0 does not raise irq_o.
- R9: The level term of pin n is data-in[n] AND level-mask[n] (offset 0x1C). It follows the adjusted input while enabled, including a change made through the polarity register alone.
- R10: irq_o is a registered OR of all edge and level terms. It asserts one clock after the first active term appears, which is the fourth edge after a masked pin rises.
- R11: A pin whose blink-enable bit (offset 0x08) is set outputs a square wave instead of its data-out bit. The wave changes level every BLINK_DIV clocks.
- R12: The read/write registers sit at word offsets 0x00 data-out, 0x04 drive-enable (active-low), 0x08 blink, 0x0C polarity, 0x18 edge-mask and 0x1C level-mask. Each returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address; bits [4:2] select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered on the access edge |
| pin_i | input | NPINS | Pad input levels, asynchronous |
| pin_o | output | NPINS | Pad output values |
| pin_oe_o | output | NPINS | Pad driver enable, active high |
| irq_o | output | 1 | Combined interrupt |

## Verification
All timing is counted from the clock edge at which a pin change or bus access is first seen:
- Read data appears after the edge that captures the access.
- Data-in and the level term see a pin change after the second edge.
- A cause bit sets on the third edge.
- irq_o follows its term one edge later: edge four for an edge source, edge three for a level source.

The bench drives at falling edges and samples irq_o and data-in exactly before and after each due edge, so a result one cycle early or late is caught. The same-cycle acknowledge and set case is staged by placing the clearing write on the third edge after the pin rise.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 5;

  typedef enum logic [2:0] {
    REG_DOUT  = 3'd0,
    REG_OE_N  = 3'd1,
    REG_BLINK = 3'd2,
    REG_POL   = 3'd3,
    REG_DIN   = 3'd4,
    REG_CAUSE = 3'd5,
    REG_EMASK = 3'd6,
    REG_LMASK = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
  parameter int unsigned DIV = 1048576
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  AST_BLINK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(phase_q)); // R11
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         ack_en_i,
  input  logic [W-1:0] ack_keep_i,
  input  logic [W-1:0] emask_i,
  input  logic [W-1:0] lmask_i,
  output logic [W-1:0] cause_o,
  output logic         irq_o
);
  logic [W-1:0] din_q, cause_q, rise, keep;
  logic         irq_q;

  assign rise = din_i & ~din_q;
  assign keep = ack_en_i ? ack_keep_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q   <= '0;
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      din_q   <= din_i;
      cause_q <= (cause_q & keep) | rise;  // new edge beats ack
      irq_q   <= |((cause_q & emask_i) | (din_i & lmask_i));
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = irq_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((cause_q & $past(rise)) == $past(rise))); // R7
  AST_NO_SPURIOUS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(rise)) == '0)); // R5
  AST_EDGE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cause_q & emask_i)) |=> irq_q); // R8
  AST_LEVEL_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(din_i & lmask_i)) |=> irq_q); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cause_q & emask_i) | (din_i & lmask_i)) == '0) |=> !irq_q); // R10
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS     = 32,
  parameter int unsigned BLINK_DIV = 1048576
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic [BUS_DW-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] dout_q, oe_n_q, blink_q, pol_q, emask_q, lmask_q;
  logic [NPINS-1:0] sync_pin, din, cause, wd, rd_word;
  logic             blink_phase, wr;
  gpio_reg_e        sel;

  assign sel = gpio_reg_e'(addr_i[4:2]);
  assign wr  = req_i & we_i;
  assign wd  = wdata_i[NPINS-1:0];

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_pin)
  );

  assign din = sync_pin ^ pol_q;

  gpio_blink #(.DIV(BLINK_DIV)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(blink_phase)
  );

  gpio_irq #(.W(NPINS)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .din_i     (din),
    .ack_en_i  (wr && sel == REG_CAUSE),
    .ack_keep_i(wd),
    .emask_i   (emask_q),
    .lmask_i   (lmask_q),
    .cause_o   (cause),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      oe_n_q  <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr) begin
      unique case (sel)
        REG_DOUT:  dout_q  <= wd;
        REG_OE_N:  oe_n_q  <= wd;
        REG_BLINK: blink_q <= wd;
        REG_POL:   pol_q   <= wd;
        REG_EMASK: emask_q <= wd;
        REG_LMASK: lmask_q <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      REG_DOUT:  rd_word = dout_q;
      REG_OE_N:  rd_word = oe_n_q;
      REG_BLINK: rd_word = blink_q;
      REG_POL:   rd_word = pol_q;
      REG_DIN:   rd_word = din;
      REG_CAUSE: rd_word = cause;
      REG_EMASK: rd_word = emask_q;
      default:   rd_word = lmask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= BUS_DW'(rd_word);
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    assign pin_o[i]    = blink_q[i] ? blink_phase : dout_q[i];
    assign pin_oe_o[i] = ~oe_n_q[i];
  end

  AST_OE_ACTIVE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == REG_OE_N) |=> (pin_oe_o == ~$past(wd))); // R2
  AST_DOUT_TO_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == REG_DOUT) |=> ((pin_o & ~blink_q) == ($past(wd) & ~blink_q))); // R2
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int unsigned NP = 32;
  localparam int unsigned BDIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;
  int            checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  gpio_irq_port #(.NPINS(NP), .BLINK_DIV(BDIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic settle_clear();
    wr(5'h0C, 32'h0);
    repeat (4) @(negedge clk);
    wr(5'h14, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(5'h00, v); chk("R1 dout", v, 32'h0);
    rd(5'h04, v); chk("R1 oe_n", v, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R1 blink", v, 32'h0);
    rd(5'h0C, v); chk("R1 pol", v, 32'h0);
    rd(5'h14, v); chk("R1 cause", v, 32'h0);
    rd(5'h18, v); chk("R1 emask", v, 32'h0);
    rd(5'h1C, v); chk("R1 lmask", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h00, 32'hDEAD_BEEF); rd(5'h00, v); chk("R12 dout", v, 32'hDEAD_BEEF);
    wr(5'h08, 32'h0F0F_0000); rd(5'h08, v); chk("R12 blink", v, 32'h0F0F_0000);
    wr(5'h0C, 32'h1357_9BDF); rd(5'h0C, v); chk("R12 pol", v, 32'h1357_9BDF);
    wr(5'h18, 32'hA5A5_5A5A); rd(5'h18, v); chk("R12 emask", v, 32'hA5A5_5A5A);
    wr(5'h1C, 32'h0000_8001); rd(5'h1C, v); chk("R12 lmask", v, 32'h0000_8001);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); chk("R3 din write ignored", v, 32'h1357_9BDF);
    wr(5'h18, 32'h0); wr(5'h1C, 32'h0); wr(5'h08, 32'h0);
    settle_clear();
    rd(5'h14, v); chk("R6 cause cleared", v, 32'h0);
  endtask

  task automatic t_output();
    wr(5'h00, 32'hA5A5_A5A5);
    wr(5'h04, 32'hFFFF_0000);
    chk("R2 oe active low", pin_oe, 32'h0000_FFFF);
    chk("R2 pin follows dout", pin_out, 32'hA5A5_A5A5);
  endtask

  task automatic t_datain();
    logic [31:0] v;
    pin = 32'h1234_5678;
    wr(5'h0C, 32'h0000_FFFF);
    repeat (3) @(negedge clk);
    rd(5'h10, v); chk("R3 din xor pol", v, 32'h1234_5678 ^ 32'h0000_FFFF);
    pin = '0;
    settle_clear();
  endtask

  task automatic t_sync();
    logic [31:0] v1, v2;
    pin[3] = 1'b1;
    @(negedge clk); req = 1; we = 0; addr = 5'h10;
    @(negedge clk); v1 = rdata;
    @(negedge clk); v2 = rdata; req = 0;
    chk("R4 edge2 still old", v1, 32'h0);
    chk("R4 edge3 new", v2, 32'h8);
  endtask

  task automatic t_cause();
    logic [31:0] v;
    rd(5'h14, v); chk("R5 cause on rise", v, 32'h8);
    pin[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd(5'h14, v); chk("R5 fall keeps cause", v, 32'h8);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R6 write 1 keeps", v, 32'h8);
    wr(5'h14, 32'hFFFF_FFF7);
    rd(5'h14, v); chk("R6 write 0 clears", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    pin[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); req = 1; we = 1; addr = 5'h14; wdata = 32'h0;
    @(negedge clk); req = 0; we = 0;
    rd(5'h14, v); chk("R7 set beats ack", v, 32'h80);
    wr(5'h14, 32'h0);
  endtask

  task automatic t_edge_irq();
    wr(5'h18, 32'h200);
    pin[9] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 irq not before edge4", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 edge irq at edge4", {31'b0, irq}, 32'h1);
    wr(5'h14, 32'h0);
    @(negedge clk);
    chk("R8 irq drops after ack", {31'b0, irq}, 32'h0);
    pin[10] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 unmasked cause silent", {31'b0, irq}, 32'h0);
    wr(5'h18, 32'h0);
    wr(5'h14, 32'h0);
  endtask

  task automatic t_level_irq();
    wr(5'h1C, 32'h1000);
    pin[12] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 level irq not at edge2", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 level irq at edge3", {31'b0, irq}, 32'h1);
    pin[12] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 level irq follows low", {31'b0, irq}, 32'h0);
    wr(5'h0C, 32'h1000);
    @(negedge clk);
    chk("R9 polarity raises level irq", {31'b0, irq}, 32'h1);
    wr(5'h1C, 32'h0);
    settle_clear();
    @(negedge clk);
    chk("R9 irq clear after unmask", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_blink();
    int   toggles = 0;
    logic prev, p5_bad = 0;
    wr(5'h04, 32'h0);
    wr(5'h00, 32'h0000_0020);
    wr(5'h08, 32'h0000_0010);
    prev = pin_out[4];
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pin_out[4] !== prev) toggles++;
      prev = pin_out[4];
      if (pin_out[5] !== 1'b1) p5_bad = 1;
    end
    chk("R11 blink toggles", toggles, 10);
    chk("R11 non-blink pin keeps dout", {31'b0, p5_bad}, 32'h0);
    wr(5'h08, 32'h0);
    chk("R11 blink off restores dout", pin_out, 32'h0000_0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_output();
    t_datain();
    t_sync();
    t_cause();
    t_set_wins();
    t_edge_irq();
    t_level_irq();
    t_blink();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule